// File: doc/BRIEF.md
# Saturating Weighted Histogram Unit

This block accumulates vector histogram updates into bin arrays held in local storage. Each operation carries an index vector and a weight vector, both split into 32-bit lanes. Every lane names a bin of one selected histogram set. A regular operation adds one to each named bin. A weighted operation adds the lane's signed weight, taken from either its low byte or its low half-word. Bin values never wrap: each result is clamped to the range of the bin data type configured for that set.

Four histogram sets are kept side by side. Each set has its own bin type (signed byte, half-word or word) and its own bin count. Writing a set's configuration also zeroes its bins. An update passes through a merge stage, a read stage and a saturate-and-write stage. Lanes that name the same bin are combined before the addition, so their sum is clamped once. A read that meets a write still in flight to the same bin takes the in-flight value, so operations can be issued on every cycle. A separate read port returns one bin per request with one cycle of latency.

Top module: `hist_unit`

## Requirements
- R1: After reset every bin of every set reads 0, `err_sticky` is 0, and every set has a bin count of 0.
- R2: With `upd_weighted` = 0, each in-range lane adds exactly one to the bin its index names.
- R3: With `upd_weighted` = 1, a lane adds bits [7:0] of its weight lane, sign-extended, when `upd_half` = 0, and bits [15:0], sign-extended, when `upd_half` = 1. The other bits of the weight lane have no effect.
- R4: Lanes of one operation that name the same bin are summed first, and the sum is added and clamped once. For example, +5 and -5 applied to a byte bin holding 125 leave it at 125.
- R5: A result above or below the configured bin type's range is clamped to that type's maximum or minimum. The bin type codes are 0 = signed byte (-128..127), 1 = signed half-word (-32768..32767) and 2 or 3 = signed word. `rd_data` returns the stored value sign-extended to 32 bits.
- R6: A lane whose full 32-bit unsigned index is greater than or equal to its set's bin count changes no bin, and it sets `err_sticky`, which then stays at 1 until reset. Other lanes of the same operation still apply. An index with nonzero upper bits never aliases onto a lower bin.
- R7: Operations issued on consecutive cycles to the same bin accumulate exactly as if each had completed before the next was issued.
- R8: Sets are independent. A configuration write (`cfg_we`) sets the bin type and bin count of `cfg_set`, with counts above DEPTH limited to DEPTH, and zeroes every bin of that set only.
- R9: A read request (`rd_en`) of bin `rd_addr` in set `rd_set` updates `rd_data` one clock later. `rd_data` holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write configuration of one set and clear its bins |
| cfg_set | input | $clog2(SETS) | Set being configured |
| cfg_type | input | 2 | Bin type code: 0 byte, 1 half-word, 2/3 word |
| cfg_bins | input | $clog2(DEPTH)+1 | Number of bins in use |
| upd_valid | input | 1 | Update operation present |
| upd_set | input | $clog2(SETS) | Set the operation updates |
| upd_weighted | input | 1 | 1 = add lane weight, 0 = add one |
| upd_half | input | 1 | Weight width: 0 = byte, 1 = half-word |
| upd_index | input | 32*LANES | Unsigned bin index per 32-bit lane (lane k at bits 32k+31:32k) |
| upd_weight | input | 32*LANES | Weight per 32-bit lane |
| rd_en | input | 1 | Read request |
| rd_set | input | $clog2(SETS) | Set to read |
| rd_addr | input | $clog2(DEPTH) | Bin to read |
| rd_data | output | 32 | Bin value, sign-extended, one cycle after request |
| err_sticky | output | 1 | Out-of-range index seen since reset |

## Verification
The hardest case to reach from the ports is an operation whose read stage hits a bin that the operation just ahead of it is still writing. Only back-to-back issue to the same set and bin exposes the forwarding path. The bench therefore drives operations on consecutive cycles to one bin, including weights of opposite sign. A stale value would then show up as a wrong final count. Saturation ordering is reached by first filling a byte bin close to its limit, then applying lanes whose separate effects would clip but whose sum would not.

// File: rtl/hist_pkg.sv
`timescale 1ns/1ps
package hist_pkg;

    typedef enum logic [1:0] {
        BT_S8  = 2'd0,
        BT_S16 = 2'd1,
        BT_S32 = 2'd2
    } bin_type_e;

    // Accumulator wide enough for a 32-bit bin plus the sum of all lane weights
    localparam int ACC_W = 40;

    function automatic logic signed [ACC_W-1:0] lane_weight(
        input logic [31:0] raw,
        input logic        weighted,
        input logic        half
    );
        logic signed [ACC_W-1:0] w;
        if (!weighted)
            w = {{(ACC_W-1){1'b0}}, 1'b1};
        else if (half)
            w = {{(ACC_W-16){raw[15]}}, raw[15:0]};
        else
            w = {{(ACC_W-8){raw[7]}}, raw[7:0]};
        return w;
    endfunction

    function automatic logic [31:0] clamp_bin(
        input logic signed [ACC_W-1:0] v,
        input bin_type_e               t
    );
        logic signed [ACC_W-1:0] lo, hi, r;
        case (t)
            BT_S8: begin
                lo = {{(ACC_W-7){1'b1}}, 7'd0};
                hi = {{(ACC_W-7){1'b0}}, {7{1'b1}}};
            end
            BT_S16: begin
                lo = {{(ACC_W-15){1'b1}}, 15'd0};
                hi = {{(ACC_W-15){1'b0}}, {15{1'b1}}};
            end
            default: begin
                lo = {{(ACC_W-31){1'b1}}, 31'd0};
                hi = {{(ACC_W-31){1'b0}}, {31{1'b1}}};
            end
        endcase
        if (v < lo)      r = lo;
        else if (v > hi) r = hi;
        else             r = v;
        return r[31:0];
    endfunction

endpackage

// File: rtl/hist_merge.sv
`timescale 1ns/1ps
module hist_merge
    import hist_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  logic [LANES*32-1:0]    idx_vec,
    input  logic [LANES*32-1:0]    wt_vec,
    input  logic                   weighted,
    input  logic                   half,
    input  logic [CW-1:0]          limit,
    output logic [LANES-1:0]       lane_we,
    output logic [LANES*AW-1:0]    lane_addr,
    output logic [LANES*ACC_W-1:0] lane_delta,
    output logic                   any_oob
);

    logic [LANES-1:0]        in_rng;
    logic signed [ACC_W-1:0] wgt [LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            in_rng[i] = idx_vec[i*32 +: 32] < 32'(limit);
            wgt[i]    = lane_weight(wt_vec[i*32 +: 32], weighted, half);
        end
        any_oob = ~&in_rng;
    end

    // The first in-range lane naming a bin owns its write and carries the summed delta
    always_comb begin
        logic signed [ACC_W-1:0] acc;
        for (int i = 0; i < LANES; i++) begin
            acc        = '0;
            lane_we[i] = in_rng[i];
            for (int j = 0; j < LANES; j++) begin
                if (in_rng[j] && idx_vec[j*32 +: 32] == idx_vec[i*32 +: 32]) begin
                    acc = acc + wgt[j];
                    if (j < i) lane_we[i] = 1'b0;
                end
            end
            lane_addr[i*AW +: AW]        = idx_vec[i*32 +: AW];
            lane_delta[i*ACC_W +: ACC_W] = acc;
        end
    end

endmodule

// File: rtl/hist_sat.sv
`timescale 1ns/1ps
module hist_sat
    import hist_pkg::*;
(
    input  logic [31:0]      old_val,
    input  logic [ACC_W-1:0] delta,
    input  bin_type_e        btype,
    output logic [31:0]      new_val
);

    logic signed [ACC_W-1:0] sum;

    always_comb begin
        sum     = $signed({{(ACC_W-32){old_val[31]}}, old_val}) + $signed(delta);
        new_val = clamp_bin(sum, btype);
    end

endmodule

// File: rtl/hist_bin_store.sv
`timescale 1ns/1ps
module hist_bin_store #(
    parameter int SETS  = 4,
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int SW    = 2,
    parameter int AW    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    wr_en,
    input  logic [SW-1:0]       wr_set,
    input  logic [LANES*AW-1:0] wr_addr,
    input  logic [LANES*32-1:0] wr_data,
    input  logic                clr_en,
    input  logic [SW-1:0]       clr_set,
    input  logic [SW-1:0]       lk_set,
    input  logic [LANES*AW-1:0] lk_addr,
    output logic [LANES*32-1:0] lk_data,
    input  logic                rd_en,
    input  logic [SW-1:0]       rd_set,
    input  logic [AW-1:0]       rd_addr,
    output logic [31:0]         rd_data
);

    localparam int ENTRIES = SETS * DEPTH;

    logic [31:0] mem [ENTRIES];

    always_comb begin
        for (int i = 0; i < LANES; i++)
            lk_data[i*32 +: 32] = mem[{lk_set, lk_addr[i*AW +: AW]}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++) mem[k] <= '0;
            rd_data <= '0;
        end else begin
            for (int i = 0; i < LANES; i++)
                if (wr_en[i]) mem[{wr_set, wr_addr[i*AW +: AW]}] <= wr_data[i*32 +: 32];
            if (clr_en)
                for (int a = 0; a < DEPTH; a++) mem[{clr_set, AW'(a)}] <= '0;
            if (rd_en) rd_data <= mem[{rd_set, rd_addr}];
        end
    end

endmodule

// File: rtl/hist_unit.sv
`timescale 1ns/1ps
module hist_unit
    import hist_pkg::*;
#(
    parameter int  LANES = 4,
    parameter int  SETS  = 4,
    parameter int  DEPTH = 64,
    localparam int SW    = $clog2(SETS),
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SW-1:0]       cfg_set,
    input  logic [1:0]          cfg_type,
    input  logic [CW-1:0]       cfg_bins,
    input  logic                upd_valid,
    input  logic [SW-1:0]       upd_set,
    input  logic                upd_weighted,
    input  logic                upd_half,
    input  logic [LANES*32-1:0] upd_index,
    input  logic [LANES*32-1:0] upd_weight,
    input  logic                rd_en,
    input  logic [SW-1:0]       rd_set,
    input  logic [AW-1:0]       rd_addr,
    output logic [31:0]         rd_data,
    output logic                err_sticky
);

    // Per-set configuration
    bin_type_e     set_type  [SETS];
    logic [CW-1:0] set_limit [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                set_type[s]  <= BT_S32;
                set_limit[s] <= '0;
            end
        end else if (cfg_we) begin
            set_type[cfg_set]  <= bin_type_e'(cfg_type);
            set_limit[cfg_set] <= (cfg_bins > CW'(DEPTH)) ? CW'(DEPTH) : cfg_bins;
        end
    end

    // Merge stage (combinational on the inputs)
    logic [LANES-1:0]       m_we;
    logic [LANES*AW-1:0]    m_addr;
    logic [LANES*ACC_W-1:0] m_delta;
    logic                   m_oob;

    hist_merge #(.LANES(LANES), .AW(AW), .CW(CW)) u_merge (
        .idx_vec   (upd_index),
        .wt_vec    (upd_weight),
        .weighted  (upd_weighted),
        .half      (upd_half),
        .limit     (set_limit[upd_set]),
        .lane_we   (m_we),
        .lane_addr (m_addr),
        .lane_delta(m_delta),
        .any_oob   (m_oob)
    );

    // Stage A: merged operation, reads storage
    logic [SW-1:0]          a_set;
    bin_type_e              a_type;
    logic [LANES-1:0]       a_we;
    logic [LANES*AW-1:0]    a_addr;
    logic [LANES*ACC_W-1:0] a_delta;

    // Stage B: old values known, saturate and write
    logic [SW-1:0]          b_set;
    bin_type_e              b_type;
    logic [LANES-1:0]       b_we;
    logic [LANES*AW-1:0]    b_addr;
    logic [LANES*ACC_W-1:0] b_delta;
    logic [31:0]            b_old [LANES];
    logic [31:0]            b_new [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_set <= '0; a_type <= BT_S32; a_we <= '0; a_addr <= '0; a_delta <= '0;
            err_sticky <= 1'b0;
        end else begin
            a_set   <= upd_set;
            a_type  <= set_type[upd_set];
            a_we    <= upd_valid ? m_we : '0;
            a_addr  <= m_addr;
            a_delta <= m_delta;
            if (upd_valid && m_oob) err_sticky <= 1'b1;
        end
    end

    logic [LANES*32-1:0] lk_data;
    logic [31:0]         a_old [LANES];

    // Forward an in-flight stage-B result over the stored value
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            a_old[i] = lk_data[i*32 +: 32];
            for (int j = 0; j < LANES; j++)
                if (b_we[j] && b_set == a_set && b_addr[j*AW +: AW] == a_addr[i*AW +: AW])
                    a_old[i] = b_new[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_set <= '0; b_type <= BT_S32; b_we <= '0; b_addr <= '0; b_delta <= '0;
            for (int i = 0; i < LANES; i++) b_old[i] <= '0;
        end else begin
            b_set   <= a_set;
            b_type  <= a_type;
            b_we    <= a_we;
            b_addr  <= a_addr;
            b_delta <= a_delta;
            for (int i = 0; i < LANES; i++) b_old[i] <= a_old[i];
        end
    end

    logic [LANES*32-1:0] st_wr_data;

    for (genvar g = 0; g < LANES; g++) begin : g_sat
        hist_sat u_sat (
            .old_val(b_old[g]),
            .delta  (b_delta[g*ACC_W +: ACC_W]),
            .btype  (b_type),
            .new_val(b_new[g])
        );
        assign st_wr_data[g*32 +: 32] = b_new[g];
    end

    hist_bin_store #(.SETS(SETS), .DEPTH(DEPTH), .LANES(LANES), .SW(SW), .AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (b_we),
        .wr_set (b_set),
        .wr_addr(b_addr),
        .wr_data(st_wr_data),
        .clr_en (cfg_we),
        .clr_set(cfg_set),
        .lk_set (a_set),
        .lk_addr(a_addr),
        .lk_data(lk_data),
        .rd_en  (rd_en),
        .rd_set (rd_set),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/hist_unit_chk.sv
`timescale 1ns/1ps
module hist_unit_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                upd_valid,
    input logic                oob,
    input logic                rd_en,
    input logic [31:0]         rd_data,
    input logic                err_sticky,
    input logic [1:0]          wtype,
    input logic [LANES-1:0]    wr_en,
    input logic [LANES*32-1:0] wr_data
);

    // R1: leaving reset, the flag and the read data are clear
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!err_sticky && rd_data == 32'd0));

    // R6: an out-of-range lane raises the flag on the next cycle
    assert_oob_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && oob) |=> err_sticky);

    // R6: the flag never drops without reset
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    // R9: read data only moves on a request
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    for (genvar g = 0; g < LANES; g++) begin : g_rng
        // R5: values written to byte and half-word bins stay in range
        assert_s8_range_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_en[g] && wtype == 2'd0) |->
            ($signed(wr_data[g*32 +: 32]) >= -128 && $signed(wr_data[g*32 +: 32]) <= 127));
        assert_s16_range_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_en[g] && wtype == 2'd1) |->
            ($signed(wr_data[g*32 +: 32]) >= -32768 && $signed(wr_data[g*32 +: 32]) <= 32767));
    end

endmodule

bind hist_unit hist_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .oob       (m_oob),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .err_sticky(err_sticky),
    .wtype     (b_type),
    .wr_en     (b_we),
    .wr_data   (st_wr_data)
);

// File: tb/tb_hist_unit.sv
`timescale 1ns/1ps
module tb_hist_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_set = '0;
    logic [1:0]   cfg_type = '0;
    logic [6:0]   cfg_bins = '0;
    logic         upd_valid = 1'b0;
    logic [1:0]   upd_set = '0;
    logic         upd_weighted = 1'b0;
    logic         upd_half = 1'b0;
    logic [127:0] upd_index = '0;
    logic [127:0] upd_weight = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_set = '0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         err_sticky;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hist_unit dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_type(cfg_type), .cfg_bins(cfg_bins),
        .upd_valid(upd_valid), .upd_set(upd_set), .upd_weighted(upd_weighted),
        .upd_half(upd_half), .upd_index(upd_index), .upd_weight(upd_weight),
        .rd_en(rd_en), .rd_set(rd_set), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_sticky(err_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] s, input logic [1:0] t, input logic [6:0] n);
        cfg_we = 1'b1; cfg_set = s; cfg_type = t; cfg_bins = n;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic update(input logic [1:0] s, input logic w, input logic h,
                          input logic [31:0] i0, i1, i2, i3,
                          input logic [31:0] w0, w1, w2, w3);
        upd_valid = 1'b1; upd_set = s; upd_weighted = w; upd_half = h;
        upd_index  = {i3, i2, i1, i0};
        upd_weight = {w3, w2, w1, w0};
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] s, input logic [5:0] a,
                            input logic [31:0] exp);
        repeat (3) @(negedge clk);
        rd_en = 1'b1; rd_set = s; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        check("R1 err after reset", {31'd0, err_sticky}, 32'd0);
        read_chk("R1 bin after reset", 2'd0, 6'd0, 32'd0);
        read_chk("R1 bin after reset", 2'd3, 6'd63, 32'd0);
    endtask

    task automatic t_regular;
        configure(2'd0, 2'd1, 7'd16);
        update(2'd0, 1'b0, 1'b0, 1, 2, 3, 4, 32'hDEAD, 32'hBEEF, 0, 0);
        read_chk("R2 regular bin1", 2'd0, 6'd1, 32'd1);
        read_chk("R2 regular bin4", 2'd0, 6'd4, 32'd1);
        read_chk("R2 untouched bin5", 2'd0, 6'd5, 32'd0);
    endtask

    task automatic t_weighted;
        update(2'd0, 1'b1, 1'b0, 7, 7, 8, 9, 32'h0000_00FE, 32'h1234_5605, 32'h7F, 32'h80);
        read_chk("R3 byte weights summed", 2'd0, 6'd7, 32'd3);
        read_chk("R3 byte weight max", 2'd0, 6'd8, 32'd127);
        read_chk("R3 byte weight min", 2'd0, 6'd9, 32'hFFFF_FF80);
        update(2'd0, 1'b1, 1'b1, 10, 11, 11, 12, 32'h0001_8000, 32'h7FFF, 32'h1, 32'hFFFF_FFFF);
        read_chk("R3 half weight", 2'd0, 6'd10, 32'hFFFF_8000);
        read_chk("R5 half bin clamps high", 2'd0, 6'd11, 32'h0000_7FFF);
        read_chk("R3 half weight -1", 2'd0, 6'd12, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide_sat;
        configure(2'd1, 2'd0, 7'd8);
        update(2'd1, 1'b1, 1'b0, 0, 1, 1, 1, 125, 0, 0, 0);
        update(2'd1, 1'b1, 1'b0, 0, 0, 1, 1, 5, 32'hFB, 1, 1);
        read_chk("R4 summed before clamp", 2'd1, 6'd0, 32'd125);
        read_chk("R4 shared bin", 2'd1, 6'd1, 32'd2);
        update(2'd1, 1'b1, 1'b0, 0, 0, 0, 0, 100, 100, 100, 100);
        read_chk("R5 byte clamps high", 2'd1, 6'd0, 32'd127);
        update(2'd1, 1'b1, 1'b0, 0, 0, 0, 0, 32'h80, 32'h80, 32'h80, 32'h80);
        read_chk("R5 byte clamps low", 2'd1, 6'd0, 32'hFFFF_FF80);
        configure(2'd3, 2'd1, 7'd4);
        update(2'd3, 1'b1, 1'b1, 2, 2, 2, 2, 32'h7FFF, 32'h7FFF, 32'h7FFF, 32'h7FFF);
        read_chk("R5 half clamps high", 2'd3, 6'd2, 32'h0000_7FFF);
        update(2'd3, 1'b1, 1'b1, 2, 2, 2, 2, 32'h8000, 32'h8000, 32'h8000, 32'h8000);
        read_chk("R5 half clamps low", 2'd3, 6'd2, 32'hFFFF_8000);
        check("R6 err still clear", {31'd0, err_sticky}, 32'd0);
    endtask

    task automatic t_out_of_range;
        update(2'd0, 1'b0, 1'b0, 16, 3, 32'hFFFF_0000, 5, 0, 0, 0, 0);
        read_chk("R6 in-range lane applies", 2'd0, 6'd3, 32'd2);
        read_chk("R6 in-range lane applies", 2'd0, 6'd5, 32'd1);
        read_chk("R6 no alias onto bin0", 2'd0, 6'd0, 32'd0);
        check("R6 err set", {31'd0, err_sticky}, 32'd1);
        update(2'd2, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
        read_chk("R6 unconfigured set ignored", 2'd2, 6'd0, 32'd0);
        check("R6 err stays set", {31'd0, err_sticky}, 32'd1);
    endtask

    task automatic t_back_to_back;
        configure(2'd2, 2'd2, 7'd4);
        for (int k = 0; k < 4; k++) update(2'd2, 1'b0, 1'b0, 0, 0, 0, 1, 0, 0, 0, 0);
        read_chk("R7 consecutive same bin", 2'd2, 6'd0, 32'd12);
        read_chk("R7 consecutive other lane", 2'd2, 6'd1, 32'd4);
        update(2'd2, 1'b1, 1'b1, 1, 1, 1, 1, 32'hFFFF, 32'hFFFF, 32'hFFFF, 32'hFFFF);
        update(2'd2, 1'b1, 1'b1, 1, 1, 1, 1, 2, 2, 2, 2);
        read_chk("R7 consecutive mixed signs", 2'd2, 6'd1, 32'd8);
    endtask

    task automatic t_reconfig;
        configure(2'd0, 2'd1, 7'd16);
        read_chk("R8 config clears own set", 2'd0, 6'd7, 32'd0);
        read_chk("R8 other set kept", 2'd1, 6'd0, 32'hFFFF_FF80);
        read_chk("R8 other set kept", 2'd3, 6'd2, 32'hFFFF_8000);
        configure(2'd1, 2'd0, 7'd127);
        update(2'd1, 1'b0, 1'b0, 63, 64, 63, 63, 0, 0, 0, 0);
        read_chk("R8 count limited to depth", 2'd1, 6'd63, 32'd3);
    endtask

    task automatic t_read_hold;
        rd_en = 1'b1; rd_set = 2'd2; rd_addr = 6'd0;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 6'd1;
        check("R9 one-cycle read", rd_data, 32'd12);
        repeat (2) @(negedge clk);
        check("R9 hold without request", rd_data, 32'd12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regular();
        t_weighted();
        t_collide_sat();
        t_out_of_range();
        t_back_to_back();
        t_reconfig();
        t_read_hold();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule